// File: doc/BRIEF.md
# Streaming Multi-Word Program Sequencer

This block runs a streamed multi-word programming operation on a flash-style array. The command decoder recognises the setup writes and pulses `start`. From then on every host bus write is read as one step of a program pass followed by a verify pass. The first write of each pass carries a real start address and the first word. Every later write carries only a word. The high address bits of each later write tell whether the stream goes on or ends, and the word address is generated inside the block by counting up from the start address.

The program pass can only clear bits to 0. The verify pass resends the same stream. Each word is read back from the array and compared with the resent word. A word that differs gets one reprogram and one more read-back; if it still differs, the operation stops with an error. The host must poll `ready` before each write. `ready` is 0 when the next write may be sent and 1 while the block is busy or has failed. A drop of the high-voltage-OK input aborts the operation at once. Once an operation is running, other commands have no effect until it ends or, after a failure, until a reset command is received.

Top module: `mwp_seq`

## Requirements
- R1: A `start` pulse with `hvOk` high moves the block from idle to the program pass, with `active`=1 and `ready`=0. A `start` given while `hvOk` is low, or while the block is already active, has no effect.
- R2: The first write of the program pass issues one array program (`arrWe`=1) of `wrData` to exactly `wrAddr`. The array stores old AND data.
- R3: A continue write has address bits 19..17 equal to those of the start address. It programs its word at the previous word address plus one, and its bits 16..0 are ignored. The word address counts modulo 2^20, so it wraps from FFFFF to 00000 without error.
- R4: A final write differs from the start address in bit 17, 18 or 19. It issues no array operation, its data is discarded, and it ends the current pass. After the program pass, the next write is again a first write (start address and first word), this time for the verify pass.
- R5: In the verify pass, each word is first read (`arrWe`=0) at its generated address. If the read value equals the resent word, no program is issued.
- R6: If the first read differs, exactly one program of the resent word is issued, followed by one more read. If that second read matches, verification goes on with the next write.
- R7: If the second read still differs, as it does when a bit has to go from 0 to 1, the block enters a failed state. In that state `err`=1, `ready`=1, `active`=1, `toggle` keeps changing every cycle, and writes are ignored with no array access. Only `rstCmd` leaves this state, and it clears `err`.
- R8: A final write in the verify pass, with every word verified, returns the block to idle: `active`=0, `ready`=0, `err`=0.
- R9: If `hvOk` is low in any cycle while the block is active and not failed, the operation aborts in the next cycle. `err` and `vppErr` are then set, `arrReq` drops and no further array operation is issued. An abort and a write arriving in the same cycle result in the abort, and the write is lost.
- R10: A write that arrives while an array operation is in progress (`ready`=1) is dropped. It sets the sticky `protoErr` flag, which is cleared only by the next accepted `start` or by `rstCmd` while idle or failed.
- R11: `rstCmd` has no effect while an operation is running and not failed.
- R12: `arrReq`, together with `arrAddr`, `arrWe` and `arrWdata`, is held until the cycle of `arrDone`. `ready` is 1 for as long as `arrReq` is 1, and 0 while the block waits for a write. `toggle` changes every cycle while `active`=1 and holds while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Setup recognised by the command decoder |
| rstCmd | input | 1 | Reset command from the decoder |
| hvOk | input | 1 | Programming voltage in range |
| wrEn | input | 1 | Host bus write strobe, one cycle per write |
| wrAddr | input | 20 | Bus write address |
| wrData | input | 16 | Bus write data |
| arrReq | output | 1 | Array operation request, held until done |
| arrWe | output | 1 | 1 = program, 0 = read |
| arrAddr | output | 20 | Array word address |
| arrWdata | output | 16 | Word to program |
| arrRdata | input | 16 | Read data, valid with arrDone |
| arrDone | input | 1 | Array operation complete (one-cycle pulse) |
| ready | output | 1 | 0 = next write may be sent, 1 = busy or failed |
| toggle | output | 1 | Changes every cycle while active |
| active | output | 1 | Operation in progress or failed |
| err | output | 1 | Operation failed |
| vppErr | output | 1 | Failure caused by a high-voltage drop |
| protoErr | output | 1 | Sticky: a write arrived while busy |

## Verification
Two events can land on the same clock edge: a host write being accepted while the block waits for one, and an abort caused by the high-voltage supply dropping. The bench drives `wrEn` low-to-high and `hvOk` high-to-low on the same half-cycle, after a first word has already been programmed. The abort must win. This is judged at the ports: both error flags are set, `arrReq` stays low, and the array write count does not change over the following cycles. A second case overlaps a busy-time write with a running array operation. That operation must complete normally and store the original word, and only the sticky protocol flag may record the dropped write.

// File: rtl/mwp_pkg.sv
package mwp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_PROG,
    S_VREAD,
    S_VPROG,
    S_VREAD2,
    S_FAIL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchFirst;
    logic advance;
    logic clrFlags;
    logic setErr;
    logic setVpp;
    logic setProto;
  } seqStrobe_t;

endpackage

// File: rtl/mwp_dp.sv
module mwp_dp
  import mwp_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int HB = 17
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] arrRdata,
  output logic          isFinal,
  output logic          match,
  output logic [AW-1:0] arrAddr,
  output logic [DW-1:0] arrWdata,
  output logic          err,
  output logic          vppErr,
  output logic          protoErr
);

  localparam int HW = AW - HB;

  logic [AW-1:0] curAddr;
  logic [HW-1:0] hiRef;
  logic [DW-1:0] wordReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      hiRef   <= '0;
      wordReg <= '0;
    end else if (strb.latchFirst) begin
      curAddr <= wrAddr;
      hiRef   <= wrAddr[AW-1:HB];
      wordReg <= wrData;
    end else if (strb.advance) begin
      curAddr <= curAddr + AW'(1);
      wordReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      err      <= 1'b0;
      vppErr   <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      if (strb.clrFlags) begin
        err      <= 1'b0;
        vppErr   <= 1'b0;
        protoErr <= 1'b0;
      end
      if (strb.setErr)   err      <= 1'b1;
      if (strb.setVpp)   vppErr   <= 1'b1;
      if (strb.setProto) protoErr <= 1'b1;
    end
  end

  assign isFinal  = (wrAddr[AW-1:HB] != hiRef);
  assign match    = (arrRdata == wordReg);
  assign arrAddr  = curAddr;
  assign arrWdata = wordReg;

endmodule

// File: rtl/mwp_ctrl.sv
module mwp_ctrl
  import mwp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rstCmd,
  input  logic       hvOk,
  input  logic       wrEn,
  input  logic       isFinal,
  input  logic       match,
  input  logic       arrDone,
  output seqStrobe_t strb,
  output logic       arrReq,
  output logic       arrWe,
  output logic       ready,
  output logic       toggle,
  output logic       active
);

  seqState_t state, stateNxt;
  logic firstPend, firstPendNxt;
  logic verPass, verPassNxt;
  logic opBusy;

  assign opBusy = (state == S_PROG) || (state == S_VREAD) ||
                  (state == S_VPROG) || (state == S_VREAD2);

  always_comb begin
    stateNxt     = state;
    firstPendNxt = firstPend;
    verPassNxt   = verPass;
    strb         = '0;

    if (opBusy && wrEn) strb.setProto = 1'b1;

    if (state != S_IDLE && state != S_FAIL && !hvOk) begin
      stateNxt    = S_FAIL;
      strb.setErr = 1'b1;
      strb.setVpp = 1'b1;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start && hvOk) begin
            strb.clrFlags = 1'b1;
            firstPendNxt  = 1'b1;
            verPassNxt    = 1'b0;
            stateNxt      = S_WAIT;
          end else if (rstCmd) begin
            strb.clrFlags = 1'b1;
          end
        end
        S_WAIT: begin
          if (wrEn) begin
            if (firstPend) begin
              strb.latchFirst = 1'b1;
              firstPendNxt    = 1'b0;
              stateNxt        = verPass ? S_VREAD : S_PROG;
            end else if (isFinal) begin
              if (!verPass) begin
                verPassNxt   = 1'b1;
                firstPendNxt = 1'b1;
              end else begin
                stateNxt = S_IDLE;
              end
            end else begin
              strb.advance = 1'b1;
              stateNxt     = verPass ? S_VREAD : S_PROG;
            end
          end
        end
        S_PROG:  if (arrDone) stateNxt = S_WAIT;
        S_VREAD: if (arrDone) stateNxt = match ? S_WAIT : S_VPROG;
        S_VPROG: if (arrDone) stateNxt = S_VREAD2;
        S_VREAD2: begin
          if (arrDone) begin
            if (match) begin
              stateNxt = S_WAIT;
            end else begin
              stateNxt    = S_FAIL;
              strb.setErr = 1'b1;
            end
          end
        end
        S_FAIL: begin
          if (rstCmd) begin
            strb.clrFlags = 1'b1;
            stateNxt      = S_IDLE;
          end
        end
        default: stateNxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      firstPend <= 1'b0;
      verPass   <= 1'b0;
      toggle    <= 1'b0;
    end else begin
      state     <= stateNxt;
      firstPend <= firstPendNxt;
      verPass   <= verPassNxt;
      if (state != S_IDLE) toggle <= ~toggle;
    end
  end

  assign arrReq = opBusy;
  assign arrWe  = (state == S_PROG) || (state == S_VPROG);
  assign ready  = opBusy || (state == S_FAIL);
  assign active = (state != S_IDLE);

endmodule

// File: rtl/mwp_seq.sv
module mwp_seq
  import mwp_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int HB = 17
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          rstCmd,
  input  logic          hvOk,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic          arrReq,
  output logic          arrWe,
  output logic [AW-1:0] arrAddr,
  output logic [DW-1:0] arrWdata,
  input  logic [DW-1:0] arrRdata,
  input  logic          arrDone,
  output logic          ready,
  output logic          toggle,
  output logic          active,
  output logic          err,
  output logic          vppErr,
  output logic          protoErr
);

  seqStrobe_t strb;
  logic isFinal;
  logic match;

  mwp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rstCmd(rstCmd), .hvOk(hvOk),
    .wrEn(wrEn), .isFinal(isFinal), .match(match), .arrDone(arrDone),
    .strb(strb), .arrReq(arrReq), .arrWe(arrWe), .ready(ready),
    .toggle(toggle), .active(active)
  );

  mwp_dp #(.AW(AW), .DW(DW), .HB(HB)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .arrRdata(arrRdata), .isFinal(isFinal), .match(match),
    .arrAddr(arrAddr), .arrWdata(arrWdata), .err(err), .vppErr(vppErr),
    .protoErr(protoErr)
  );

endmodule

// File: rtl/mwp_seq_chk.sv
module mwp_seq_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          rstCmd,
  input logic          hvOk,
  input logic          wrEn,
  input logic          arrReq,
  input logic          arrDone,
  input logic [AW-1:0] arrAddr,
  input logic          ready,
  input logic          active,
  input logic          err,
  input logic          vppErr,
  input logic          protoErr
);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (arrReq && !arrDone && hvOk) |=> (arrReq && $stable(arrAddr)));

  assert_ready_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    arrReq |-> ready);

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (err && !rstCmd) |=> err);

  assert_vpp_implies_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    vppErr |-> err);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    (active && !hvOk && !err) |=> (err && vppErr && !arrReq));

  assert_proto_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protoErr) |-> $past(wrEn && ready));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!ready && !arrReq));

endmodule

bind mwp_seq mwp_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rstN(rstN), .rstCmd(rstCmd), .hvOk(hvOk), .wrEn(wrEn),
  .arrReq(arrReq), .arrDone(arrDone), .arrAddr(arrAddr), .ready(ready),
  .active(active), .err(err), .vppErr(vppErr), .protoErr(protoErr)
);

// File: tb/test_mwp_seq.sv
`timescale 1ns/1ps
module test_mwp_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        rstCmd = 1'b0;
  logic        hvOk = 1'b1;
  logic        wrEn = 1'b0;
  logic [19:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        arrReq, arrWe;
  logic [19:0] arrAddr;
  logic [15:0] arrWdata;
  logic [15:0] arrRdata = '0;
  logic        arrDone = 1'b0;
  logic        ready, toggle, active, err, vppErr, protoErr;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  // array model controls
  int          lat = 2;
  int          cnt = 0;
  logic [15:0] mem [64];
  logic [19:0] logAddr [256];
  int          wrCnt = 0;
  logic        wipe = 1'b0;
  logic        pokeEn = 1'b0;
  logic [5:0]  pokeIdx = '0;
  logic [15:0] pokeVal = '0;

  always #5 clk = ~clk;

  mwp_seq i_mwp_seq (
    .clk(clk), .rstN(rstN), .start(start), .rstCmd(rstCmd), .hvOk(hvOk),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .arrReq(arrReq),
    .arrWe(arrWe), .arrAddr(arrAddr), .arrWdata(arrWdata),
    .arrRdata(arrRdata), .arrDone(arrDone), .ready(ready), .toggle(toggle),
    .active(active), .err(err), .vppErr(vppErr), .protoErr(protoErr)
  );

  // array model: program stores old AND data, read returns the word
  always @(posedge clk) begin
    if (wipe) begin
      for (int k = 0; k < 64; k++) mem[k] <= 16'hFFFF;
    end else if (pokeEn) begin
      mem[pokeIdx] <= pokeVal;
    end
    if (arrDone) begin
      arrDone <= 1'b0;
      cnt     <= 0;
    end else if (arrReq) begin
      if (cnt >= lat) begin
        arrDone <= 1'b1;
        cnt     <= 0;
        if (arrWe) begin
          mem[arrAddr[5:0]] <= mem[arrAddr[5:0]] & arrWdata;
          logAddr[wrCnt[7:0]] <= arrAddr;
          wrCnt <= wrCnt + 1;
        end else begin
          arrRdata <= mem[arrAddr[5:0]];
        end
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      cnt <= 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
  endtask

  task automatic pulseRst();
    rstCmd = 1'b1; @(negedge clk); rstCmd = 1'b0; @(negedge clk);
  endtask

  task automatic wipeMem();
    wipe = 1'b1; @(negedge clk); wipe = 1'b0;
  endtask

  task automatic poke(input logic [5:0] idx, input logic [15:0] val);
    pokeIdx = idx; pokeVal = val; pokeEn = 1'b1; @(negedge clk); pokeEn = 1'b0;
  endtask

  task automatic busWrite(input logic [19:0] a, input logic [15:0] d);
    while (ready) @(negedge clk);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (ready) @(negedge clk);
  endtask

  function automatic logic [15:0] datOf(input logic [19:0] sa, input int i);
    return 16'((int'(sa) * 7 + i * 961) ^ 16'hA5A5);
  endfunction

  // one full program + verify run of n words
  task automatic runSweep(input logic [19:0] sa, input int n, input int fbit);
    logic [19:0] fa;
    int base;
    wipeMem();
    base = wrCnt;
    fa = sa ^ (20'h1 << fbit);
    pulseStart();
    chk("R1 active after start", 32'(active), 32'd1);
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < n; i++) begin
        if (i == 0) busWrite(sa, datOf(sa, i));
        else busWrite({sa[19:17], 17'((i * 4951 + pass * 77) & 17'h1FFFF)}, datOf(sa, i));
      end
      busWrite(fa, 16'h0000);  // R4 final write, data dropped
    end
    waitIdle();
    chk("R8 idle after verify", 32'(active), 32'd0);
    chk("R8 no error", 32'(err), 32'd0);
    chk("R5 verify issues no program on match", 32'(wrCnt - base), 32'(n));
    for (int i = 0; i < n; i++) begin
      chk("R2 stored word", 32'(mem[6'(sa + 20'(i))]), 32'(datOf(sa, i)));
      chk("R3 generated address", 32'(logAddr[8'(base + i)]), 32'(20'(sa + 20'(i))));
    end
  endtask

  initial begin
    logic [19:0] starts [4];
    int base;
    logic t1, t2;
    starts[0] = 20'h00000; starts[1] = 20'h2A013;
    starts[2] = 20'h7FFFD; starts[3] = 20'hFFFFE;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 reset active", 32'(active), 32'd0);
    chk("R12 reset ready", 32'(ready), 32'd0);
    chk("R7 reset err", 32'(err), 32'd0);
    chk("R12 reset arrReq", 32'(arrReq), 32'd0);
    t1 = toggle; @(negedge clk);
    chk("R12 toggle holds idle", 32'(toggle), 32'(t1));

    // R1: start ignored with supply low
    hvOk = 1'b0; pulseStart(); hvOk = 1'b1;
    chk("R1 start ignored hv low", 32'(active), 32'd0);

    // R2 R3 R4 R5 R8: sweep starts (incl. wrap) and lengths
    for (int s = 0; s < 4; s++)
      for (int n = 1; n <= 5; n++)
        runSweep(starts[s], n, 17 + (n % 3));

    // R6: lost word reprogrammed once during verify
    wipeMem(); base = wrCnt;
    pulseStart();
    busWrite(20'h00010, 16'h00FF); busWrite(20'h00000, 16'h0F0F);
    busWrite(20'h40000, 16'h0);
    waitIdle();
    poke(6'h10, 16'hFFFF);
    busWrite(20'h00010, 16'h00FF); busWrite(20'h1FFFF, 16'h0F0F);
    busWrite(20'h80010, 16'h0);
    waitIdle();
    chk("R6 one reprogram", 32'(wrCnt - base), 32'd3);
    chk("R6 reprogram address", 32'(logAddr[8'(base + 2)]), 32'h00010);
    chk("R6 word restored", 32'(mem[6'h10]), 32'h00FF);
    chk("R6 pass ends idle", 32'(active), 32'd0);
    chk("R6 no error", 32'(err), 32'd0);

    // R7: 0->1 needed, verify fails
    wipeMem(); base = wrCnt;
    pulseStart();
    busWrite(20'h00020, 16'h1234); busWrite(20'h20020, 16'h0);
    busWrite(20'h00020, 16'h1235);
    repeat (20) @(negedge clk);
    chk("R7 err set", 32'(err), 32'd1);
    chk("R7 vppErr clear", 32'(vppErr), 32'd0);
    chk("R7 ready stays busy", 32'(ready), 32'd1);
    chk("R7 still active", 32'(active), 32'd1);
    chk("R7 one retry program", 32'(wrCnt - base), 32'd2);
    t1 = toggle; @(negedge clk); t2 = toggle;
    chk("R7 toggle running", 32'(t1 ^ t2), 32'd1);
    wrAddr = 20'h00021; wrData = 16'h0000; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 write ignored when failed", 32'(wrCnt - base), 32'd2);
    chk("R7 word unchanged", 32'(mem[6'h21]), 32'hFFFF);
    pulseRst();
    chk("R7 reset cmd leaves fail", 32'(active), 32'd0);
    chk("R7 reset cmd clears err", 32'(err), 32'd0);

    // R9: supply drop during an array program
    lat = 6; wipeMem(); base = wrCnt;
    pulseStart();
    busWrite(20'h00030, 16'hAAAA);
    @(negedge clk);
    chk("R12 busy during op", 32'(ready), 32'd1);
    hvOk = 1'b0;
    @(negedge clk);
    chk("R9 err on abort", 32'(err), 32'd1);
    chk("R9 vppErr on abort", 32'(vppErr), 32'd1);
    chk("R9 request dropped", 32'(arrReq), 32'd0);
    repeat (10) @(negedge clk);
    chk("R9 no array write", 32'(wrCnt - base), 32'd0);
    hvOk = 1'b1;
    pulseRst();
    chk("R9 cleared by reset cmd", 32'(vppErr), 32'd0);

    // R9: abort coincides with accepted write
    lat = 1; wipeMem(); base = wrCnt;
    pulseStart();
    busWrite(20'h00031, 16'h5555);
    waitIdle();
    wrAddr = 20'h00000; wrData = 16'h0000; wrEn = 1'b1; hvOk = 1'b0;
    @(negedge clk); wrEn = 1'b0;
    chk("R9 coincident abort err", 32'(err & vppErr), 32'd1);
    chk("R9 coincident no request", 32'(arrReq), 32'd0);
    repeat (6) @(negedge clk);
    chk("R9 coincident write lost", 32'(wrCnt - base), 32'd1);
    chk("R9 next word untouched", 32'(mem[6'h32]), 32'hFFFF);
    hvOk = 1'b1;
    pulseRst();

    // R10: write while busy is dropped
    lat = 4; wipeMem(); base = wrCnt;
    pulseStart();
    busWrite(20'h00008, 16'h1111);
    chk("R12 ready during op", 32'(ready), 32'd1);
    wrAddr = 20'h00000; wrData = 16'h0000; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    chk("R10 protoErr set", 32'(protoErr), 32'd1);
    waitIdle();
    chk("R12 ready low waiting", 32'(ready), 32'd0);
    busWrite(20'h60000, 16'h0);
    busWrite(20'h00008, 16'h1111); busWrite(20'h60000, 16'h0);
    waitIdle();
    chk("R10 busy write no effect", 32'(mem[6'h08]), 32'h1111);
    chk("R10 single program", 32'(wrCnt - base), 32'd1);
    chk("R10 sequence completed", 32'(active), 32'd0);
    chk("R10 protoErr sticky", 32'(protoErr), 32'd1);
    pulseStart();
    chk("R10 cleared by start", 32'(protoErr), 32'd0);

    // R11: reset cmd and start ignored while running
    wipeMem(); base = wrCnt;
    busWrite(20'h00004, 16'h2222);
    waitIdle();
    pulseRst();
    chk("R11 reset cmd ignored", 32'(active), 32'd1);
    pulseStart();
    busWrite(20'h00777, 16'h3333);
    waitIdle();
    chk("R11 start ignored, address continues", 32'(logAddr[8'(base + 1)]), 32'h00005);
    busWrite(20'hE0000, 16'h0);
    busWrite(20'h00004, 16'h2222); busWrite(20'h00000, 16'h3333);
    busWrite(20'hE0000, 16'h0);
    waitIdle();
    chk("R11 run completes", 32'(active | err), 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule